// File: doc/BRIEF.md
# Dual-Clock FIFO with Optional Read-Past-Empty

This block moves data words from one clock domain to another through a small storage array. The writer pushes words on its own clock. The reader pops them on an unrelated clock. Each side keeps a binary pointer one bit wider than the address. Only the Gray-coded form of each pointer crosses to the other side, through a chain of flip-flops.

The read side has two modes.
- In standard mode, a word appears on the output one read cycle after it is requested.
- In fall-through mode, the oldest word is already on the output before any request, and a read consumes it.

A low-occupancy flag compares the reader's view of the fill level against a programmable offset. The number of extra synchronizer stages on the write-pointer path can be set from 0 to 3. This trades flag latency for settling margin.

Illegal reads are handled in one of two ways, chosen by a configuration input. They can be refused and reported by a registered error flag. Or they can be allowed to proceed: the read pointer keeps advancing and the output returns whatever the array last held at the next address. Writes into a full FIFO are dropped and reported on the write side. All configuration inputs are meant to be static while either domain is out of reset.

Top module: `xclk_fifo`

## Requirements
- R1: After both synchronous active-low resets have been held and released, `empty`=1, `almost_empty`=1, `full`=0, `rd_err`=0, `wr_err`=0 and `rd_data`=0.
- R2: In standard mode (`cfg_fwft`=0), words leave in the order they were written. `rd_data` takes the next word at the first `rd_clk` edge that samples `rd_en`=1 while `empty`=0.
- R3: In fall-through mode (`cfg_fwft`=1), the oldest stored word is shown on `rd_data` with `rd_en` low and `empty`=0. Each sampled `rd_en` consumes the shown word and shows the next. `empty` rises only at the edge that consumes the last shown word.
- R4: With `cfg_rd_past_empty`=0, `rd_en` sampled while `empty`=1 sets `rd_err` for the following `rd_clk` cycle. The read pointer does not move, so the next word written is the next word read. In standard mode `rd_data` keeps its previous value.
- R5: With `cfg_rd_past_empty`=1, a read while empty still advances the read pointer. `rd_data` then shows the array contents at the following address, which are left over from an earlier write. `rd_err` stays 0.
- R6: `almost_empty` is a registered flag that is 1 when occupancy ≤ `cfg_ae_level`+1. Occupancy is the synchronized write pointer minus the read pointer, plus one in fall-through mode when a word is held on `rd_data`. With level 4 and six words stored in fall-through mode, the flag is 0. It rises at the edge after the read that leaves five.
- R7: When the final word of a burst takes occupancy above the threshold, `almost_empty` falls at rising `rd_clk` edge number `cfg_sync_extra`+3, counted after the `wr_clk` edge that wrote that word.
- R8: `full` is 1 when 2^`AW` words are held. A write while full is dropped and sets `wr_err` for the next `wr_clk` cycle. The dropped word never appears on the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| full | output | 1 | FIFO holds 2^AW words (write-domain view) |
| wr_err | output | 1 | Previous write was dropped because FIFO was full |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Output word |
| empty | output | 1 | Nothing readable (read-domain view) |
| almost_empty | output | 1 | Registered low-occupancy flag |
| rd_err | output | 1 | Previous read hit an empty FIFO while refusing such reads |
| cfg_fwft | input | 1 | 1 = fall-through read mode, 0 = standard |
| cfg_rd_past_empty | input | 1 | 1 = reads while empty advance the pointer |
| cfg_sync_extra | input | 2 | Extra write-pointer synchronizer stages, 0 to 3 |
| cfg_ae_level | input | AW+1 | Almost-empty offset |

## Verification
The bench counts `rd_clk` edges from the final write to the fall of `almost_empty`, with sync settings 0 and 3. A tap on the wrong stage of the pointer chain, or a missing flag register, shifts that count by one.

It reads past empty both ways:
- When reads past empty are refused, a design that advanced the pointer anyway would return the wrong word on the next valid read.
- When they are allowed, a design that did not advance the pointer, or that read the wrong address, would return something other than the leftover word at the next slot.

The fall-through tests look at two timings. A design that dropped `empty` one word early would be caught, and so would one whose occupancy left out the held word, because the flag would then rise one read too soon. Filling to capacity and writing once more shows whether the dropped word is really dropped.

// File: rtl/xclk_fifo_pkg.sv
// Shared helpers for the dual-clock FIFO: pointer code conversion and the
// read-side action type. Conversions work on 32-bit values; callers truncate.
package xclk_fifo_pkg;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,  // no pointer movement
        RD_POP   = 2'd1,  // take a stored word
        RD_STALE = 2'd2   // read past empty, pointer still advances
    } rd_act_e;

    // Binary to reflected Gray code
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code to binary
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xfifo_mem.sv
// Storage array: written on the write clock, read combinationally by address.
// Assumes the reader only uses an address after that slot's pointer has crossed.
module xfifo_mem #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store one word per accepted write
    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Asynchronous read of the addressed slot
    assign rdata = cells[raddr];

endmodule

// File: rtl/xfifo_sync.sv
// Flip-flop chain that carries a Gray-coded pointer into another clock domain.
// Two base stages plus 0..XMAX extra stages chosen by 'extra'.
// Assumes 'extra' is static while out of reset.
module xfifo_sync #(
    parameter int PW   = 5,
    parameter int XMAX = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    extra,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    localparam int NST = XMAX + 2;

    logic [NST-1:0][PW-1:0] st;

    // Shift the pointer through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st[0] <= d;
            for (int i = 1; i < NST; i++) begin
                st[i] <= st[i-1];
            end
        end
    end

    // Pick the tap after base stages plus the selected extra count
    always_comb begin
        q = st[NST-1];
        for (int k = 1; k < NST; k++) begin
            if (k == 32'(extra) + 1) begin
                q = st[k];
            end
        end
    end

endmodule

// File: rtl/xfifo_wr_ctl.sv
// Write-side control: pointer in binary and Gray form, full detection
// against the synchronized read pointer, and the dropped-write flag.
// Assumes AW >= 2.
module xfifo_wr_ctl #(
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rptr_gray_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wptr_gray,
    output logic          full,
    output logic          wr_err
);
    import xclk_fifo_pkg::*;

    localparam int PW = AW + 1;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;

    // Full when the pointers differ only in the two top Gray bits
    assign full    = (wptr_gray == {~rptr_gray_sync[PW-1:PW-2], rptr_gray_sync[PW-3:0]});
    assign we      = wr_en && !full;
    assign waddr   = wbin[AW-1:0];
    assign wbin_nx = wbin + PW'(1);

    // Advance the write pointer and record dropped writes
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin      <= '0;
            wptr_gray <= '0;
            wr_err    <= 1'b0;
        end else begin
            wr_err <= wr_en && full;
            if (we) begin
                wbin      <= wbin_nx;
                wptr_gray <= PW'(bin2gray(32'(wbin_nx)));
            end
        end
    end

endmodule

// File: rtl/xfifo_rd_ctl.sv
// Read-side control: read pointer, standard or fall-through output register,
// empty and almost-empty flags, read-error flag and the read-past-empty option.
// Assumes configuration inputs are static while out of reset.
module xfifo_rd_ctl #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic          cfg_fwft,
    input  logic          cfg_rd_past_empty,
    input  logic [AW:0]   cfg_ae_level,
    input  logic [AW:0]   wptr_gray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr_gray,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty,
    output logic          rd_err
);
    import xclk_fifo_pkg::*;

    localparam int PW = AW + 1;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wq_bin;
    logic [PW-1:0] mem_cnt;
    logic [PW-1:0] occ;
    logic          mem_empty;
    logic          held;
    logic          drop;
    logic          ae_nx;
    rd_act_e       act;

    assign wq_bin    = PW'(gray2bin(32'(wptr_gray_sync)));
    assign mem_cnt   = wq_bin - rbin;
    assign mem_empty = (mem_cnt == '0);
    assign rbin_nx   = rbin + PW'(1);
    assign raddr     = rbin[AW-1:0];
    assign empty     = cfg_fwft ? !held : mem_empty;
    assign occ       = mem_cnt + PW'(cfg_fwft && held);
    assign ae_nx     = ({1'b0, occ} <= ({1'b0, cfg_ae_level} + (PW+1)'(1)));

    // Decide the pointer action for this read cycle
    always_comb begin
        act  = RD_IDLE;
        drop = 1'b0;
        if (cfg_fwft) begin
            drop = held && rd_en;
            if ((!held || rd_en) && !mem_empty) begin
                act = RD_POP;
            end else if (rd_en && !held && cfg_rd_past_empty) begin
                act = RD_STALE;
            end
        end else if (rd_en) begin
            if (!mem_empty) begin
                act = RD_POP;
            end else if (cfg_rd_past_empty) begin
                act = RD_STALE;
            end
        end
    end

    // Update pointer, output word, held marker and flags
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin         <= '0;
            rptr_gray    <= '0;
            rd_data      <= '0;
            held         <= 1'b0;
            almost_empty <= 1'b1;
            rd_err       <= 1'b0;
        end else begin
            rd_err       <= rd_en && empty && !cfg_rd_past_empty;
            almost_empty <= ae_nx;
            if (act != RD_IDLE) begin
                rd_data   <= mem_rdata;
                rbin      <= rbin_nx;
                rptr_gray <= PW'(bin2gray(32'(rbin_nx)));
            end
            if (!cfg_fwft) begin
                held <= 1'b0;
            end else if (act == RD_POP) begin
                held <= 1'b1;
            end else if (drop) begin
                held <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/xclk_fifo.sv
// Dual-clock FIFO top: storage, write control, read control and two pointer
// synchronizers (write pointer with selectable depth, read pointer fixed at two).
// Assumes both resets are held together for a few cycles of each clock.
module xclk_fifo #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          wr_err,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty,
    output logic          rd_err,
    input  logic          cfg_fwft,
    input  logic          cfg_rd_past_empty,
    input  logic [1:0]    cfg_sync_extra,
    input  logic [AW:0]   cfg_ae_level
);
    localparam int PW = AW + 1;

    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_rdata;
    logic [PW-1:0] wptr_gray;
    logic [PW-1:0] rptr_gray;
    logic [PW-1:0] wptr_gray_sync;
    logic [PW-1:0] rptr_gray_sync;

    xfifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    xfifo_wr_ctl #(.AW(AW)) u_wr (
        .wr_clk         (wr_clk),
        .wr_rst_n       (wr_rst_n),
        .wr_en          (wr_en),
        .rptr_gray_sync (rptr_gray_sync),
        .we             (we),
        .waddr          (waddr),
        .wptr_gray      (wptr_gray),
        .full           (full),
        .wr_err         (wr_err)
    );

    xfifo_sync #(.PW(PW), .XMAX(3)) u_wsync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .extra (cfg_sync_extra),
        .d     (wptr_gray),
        .q     (wptr_gray_sync)
    );

    xfifo_sync #(.PW(PW), .XMAX(3)) u_rsync (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .extra (2'b00),
        .d     (rptr_gray),
        .q     (rptr_gray_sync)
    );

    xfifo_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .rd_clk            (rd_clk),
        .rd_rst_n          (rd_rst_n),
        .rd_en             (rd_en),
        .cfg_fwft          (cfg_fwft),
        .cfg_rd_past_empty (cfg_rd_past_empty),
        .cfg_ae_level      (cfg_ae_level),
        .wptr_gray_sync    (wptr_gray_sync),
        .mem_rdata         (mem_rdata),
        .raddr             (raddr),
        .rptr_gray         (rptr_gray),
        .rd_data           (rd_data),
        .empty             (empty),
        .almost_empty      (almost_empty),
        .rd_err            (rd_err)
    );

endmodule

// File: rtl/xclk_fifo_chk.sv
// Property checker for the dual-clock FIFO, attached to every instance by bind.
module xclk_fifo_chk #(
    parameter int DW = 16,
    parameter int PW = 5
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          wr_en,
    input logic          full,
    input logic          wr_err,
    input logic [PW-1:0] wptr_gray,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          empty,
    input logic          rd_err,
    input logic          cfg_fwft,
    input logic          cfg_rd_past_empty
);
    AST_WR_ERR_ON_FULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && full) |=> wr_err); // R8
    AST_WR_ERR_CAUSE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_err |-> $past(wr_en && full)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && full) |=> $stable(wptr_gray)); // R8
    AST_WPTR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1); // R7
    AST_RD_ERR_ON_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && empty && !cfg_rd_past_empty) |=> rd_err); // R4
    AST_DOUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && empty && !cfg_rd_past_empty && !cfg_fwft) |=> $stable(rd_data)); // R4
    AST_NO_ERR_PAST_EMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        cfg_rd_past_empty |=> !rd_err); // R5
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .PW(AW + 1)) u_chk (
    .wr_clk            (wr_clk),
    .wr_rst_n          (wr_rst_n),
    .wr_en             (wr_en),
    .full              (full),
    .wr_err            (wr_err),
    .wptr_gray         (wptr_gray),
    .rd_clk            (rd_clk),
    .rd_rst_n          (rd_rst_n),
    .rd_en             (rd_en),
    .rd_data           (rd_data),
    .empty             (empty),
    .rd_err            (rd_err),
    .cfg_fwft          (cfg_fwft),
    .cfg_rd_past_empty (cfg_rd_past_empty)
);

// File: tb/xclk_fifo_test.sv
`timescale 1ns/100ps
// Directed bench: one task per scenario, each checking its own results.
module xclk_fifo_test;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          full, wr_err, empty, almost_empty, rd_err;
    logic [DW-1:0] rd_data;
    logic          cfg_fwft = 1'b0;
    logic          cfg_rd_past_empty = 1'b0;
    logic [1:0]    cfg_sync_extra = 2'd0;
    logic [AW:0]   cfg_ae_level = 5'd4;

    int n_chk = 0;
    int n_err = 0;

    xclk_fifo #(.DW(DW), .AW(AW)) uut (
        .wr_clk (wr_clk), .wr_rst_n (wr_rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .full (full), .wr_err (wr_err),
        .rd_clk (rd_clk), .rd_rst_n (rd_rst_n), .rd_en (rd_en), .rd_data (rd_data),
        .empty (empty), .almost_empty (almost_empty), .rd_err (rd_err),
        .cfg_fwft (cfg_fwft), .cfg_rd_past_empty (cfg_rd_past_empty),
        .cfg_sync_extra (cfg_sync_extra), .cfg_ae_level (cfg_ae_level)
    );

    // 250 MHz write clock; read clock offset so edges never coincide
    always #2 wr_clk = ~wr_clk;
    initial begin
        #0.5;
        forever #3 rd_clk = ~rd_clk;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic fwft, input logic past, input logic [1:0] xs, input logic [AW:0] lvl);
        wr_en = 1'b0;
        rd_en = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        cfg_fwft = fwft;
        cfg_rd_past_empty = past;
        cfg_sync_extra = xs;
        cfg_ae_level = lvl;
        repeat (4) @(posedge rd_clk);
        repeat (4) @(posedge wr_clk);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        #1;
    endtask

    task automatic wr_cycle(input logic en, input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = en;
        wr_data = d;
        @(posedge wr_clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_cycle(input logic en);
        @(negedge rd_clk);
        rd_en = en;
        @(posedge rd_clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (12) @(posedge rd_clk);
        repeat (8) @(posedge wr_clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, 2'd0, 5'd4);
        chk("R1", "empty", 32'(empty), 1);
        chk("R1", "almost_empty", 32'(almost_empty), 1);
        chk("R1", "full", 32'(full), 0);
        chk("R1", "rd_err", 32'(rd_err), 0);
        chk("R1", "wr_err", 32'(wr_err), 0);
        chk("R1", "rd_data", 32'(rd_data), 0);
    endtask

    task automatic t_full_and_order();
        do_reset(1'b0, 1'b0, 2'd0, 5'd4);
        for (int i = 0; i < DEPTH; i++) wr_cycle(1'b1, DW'(16'h0100 + i));
        chk("R8", "full after filling", 32'(full), 1);
        wr_cycle(1'b1, 16'hBAD0);
        chk("R8", "wr_err after write while full", 32'(wr_err), 1);
        wr_cycle(1'b0, '0);
        chk("R8", "wr_err clears", 32'(wr_err), 0);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            rd_cycle(1'b1);
            chk("R2", "word order", 32'(rd_data), 32'(16'h0100 + i));
        end
        chk("R8", "dropped word absent, empty", 32'(empty), 1);
        settle();
        chk("R8", "full clears after drain", 32'(full), 0);
    endtask

    task automatic t_past_empty();
        do_reset(1'b0, 1'b1, 2'd0, 5'd4);
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, DW'(16'h0200 + i));
        settle();
        for (int i = 0; i < 3; i++) begin
            rd_cycle(1'b1);
            chk("R2", "word order", 32'(rd_data), 32'(16'h0200 + i));
        end
        rd_cycle(1'b1);
        chk("R5", "stale word at slot 3", 32'(rd_data), 32'h0103);
        chk("R5", "no rd_err", 32'(rd_err), 0);
        rd_cycle(1'b1);
        chk("R5", "stale word at slot 4", 32'(rd_data), 32'h0104);
    endtask

    task automatic t_refuse_empty();
        do_reset(1'b0, 1'b0, 2'd0, 5'd4);
        wr_cycle(1'b1, 16'h0300);
        wr_cycle(1'b1, 16'h0301);
        settle();
        rd_cycle(1'b1);
        rd_cycle(1'b1);
        chk("R2", "second word", 32'(rd_data), 32'h0301);
        rd_cycle(1'b1);
        chk("R4", "rd_err after empty read", 32'(rd_err), 1);
        chk("R4", "rd_data held", 32'(rd_data), 32'h0301);
        rd_cycle(1'b0);
        chk("R4", "rd_err clears", 32'(rd_err), 0);
        wr_cycle(1'b1, 16'h0302);
        settle();
        rd_cycle(1'b1);
        chk("R4", "pointer unmoved, next word", 32'(rd_data), 32'h0302);
    endtask

    task automatic t_fwft();
        do_reset(1'b1, 1'b0, 2'd0, 5'd4);
        chk("R3", "empty at start", 32'(empty), 1);
        for (int i = 0; i < 3; i++) wr_cycle(1'b1, DW'(16'h0400 + i));
        settle();
        chk("R3", "shown without request", 32'(rd_data), 32'h0400);
        chk("R3", "not empty", 32'(empty), 0);
        rd_cycle(1'b1);
        chk("R3", "next shown", 32'(rd_data), 32'h0401);
        rd_cycle(1'b1);
        chk("R3", "last shown", 32'(rd_data), 32'h0402);
        chk("R3", "not empty while last shown", 32'(empty), 0);
        rd_cycle(1'b1);
        chk("R3", "empty after last consumed", 32'(empty), 1);
    endtask

    task automatic t_ae_threshold();
        do_reset(1'b1, 1'b0, 2'd0, 5'd4);
        for (int i = 0; i < 6; i++) wr_cycle(1'b1, DW'(16'h0500 + i));
        settle();
        chk("R6", "six words above threshold", 32'(almost_empty), 0);
        rd_cycle(1'b1);
        chk("R6", "flag not yet risen", 32'(almost_empty), 0);
        rd_cycle(1'b0);
        chk("R6", "flag risen with five left", 32'(almost_empty), 1);
    endtask

    task automatic t_ae_latency(input logic [1:0] xs);
        int n;
        do_reset(1'b0, 1'b0, xs, 5'd4);
        for (int i = 0; i < 5; i++) wr_cycle(1'b1, DW'(16'h0600 + i));
        settle();
        chk("R7", "flag high with five", 32'(almost_empty), 1);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = 16'h0605;
        @(posedge wr_clk);
        fork
            begin
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
        join_none
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge rd_clk);
            n++;
            #1;
            if (!almost_empty) break;
        end
        chk("R7", "rd edges to flag fall", 32'(n), 32'(xs) + 3);
    endtask

    initial begin
        #800000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_full_and_order();
        t_past_empty();
        t_refuse_empty();
        t_fwft();
        t_ae_threshold();
        t_ae_latency(2'd0);
        t_ae_latency(2'd3);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule